// File: doc/BRIEF.md
# Auto-Incrementing Byte-Addressed Pointer Register

This block holds a 16-bit pointer that a byte-wide CPU sees as two adjacent memory locations. Software loads the pointer with two ordinary store cycles, one per byte, in either order. The pointer can then step forward by one or by two with a single strobe. The carry runs across the full width, so software never patches the high byte by hand. The full value is also output for address generation.

A sequencer that runs alongside the CPU can put either byte of the pointer onto the CPU read bus in any cycle, whatever the normal select says. An indirect jump can then take its operand straight from the pointer. Reads are combinational from the register, so a read always shows the result of any step taken in an earlier cycle.

Top module: `auto_ptr_reg`

## Requirements
- R1: While reset is low the pointer is 0000h, and it stays 0000h after reset is released until the first write or step.
- R2: A write cycle (`sel` and `wr_en` high) with `byte_sel`=0 replaces bits 7:0 with `wdata`, and with `byte_sel`=1 replaces bits 15:8. The other byte is kept, and the change is visible on `ptr_q` after the clock edge.
- R3: `step_one` alone adds 1 to the full 16-bit value at the next edge, with the carry from bit 7 into bit 8, and FFFFh wraps to 0000h.
- R4: `step_two` adds 2 at the next edge. FFFEh becomes 0000h and FFFFh becomes 0001h. When both strobes are high together, the step is 2.
- R5: `ovr_lo` drives bits 7:0 onto `rdata` and `ovr_hi` drives bits 15:8, with `rdata_oe` high. Both ignore `sel`, `rd_en` and `byte_sel`. When both are high, the low byte is driven.
- R6: When a write and a step strobe fall in the same cycle, the write is applied, the step is dropped, and the unwritten byte keeps its old value.
- R7: Without an override, a read (`sel` and `rd_en` high, `wr_en` low) returns the byte chosen by `byte_sel` in the same cycle, with `rdata_oe` high. Otherwise `rdata_oe` is low and `rdata` is 00h.
- R8: With no write and no step strobe, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Normal address decode hit for the pointer pair |
| byte_sel | input | 1 | 0 selects the low byte, 1 selects the high byte |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe |
| wdata | input | 8 | CPU write data |
| step_one | input | 1 | Advance the pointer by one |
| step_two | input | 1 | Advance the pointer by two |
| ovr_lo | input | 1 | Sequencer forces the low byte onto the read bus |
| ovr_hi | input | 1 | Sequencer forces the high byte onto the read bus |
| rdata | output | 8 | Read data to the CPU bus |
| rdata_oe | output | 1 | Read bus drive enable |
| ptr_q | output | 16 | Current pointer value |

## Verification
A CPU byte store and a step strobe can arrive in the same cycle. So can a sequencer override and a normal CPU read or write. The random stimulus raises writes, both strobes and both overrides independently in every cycle, so these collisions come up often. Directed cycles then aim a write at each byte while a strobe is high, near a carry boundary. A bench model that lets the write win predicts every byte. The bus outputs are compared in the cycle the inputs are applied, and the pointer is compared after the next edge.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;
endpackage

// File: rtl/aptr_step_sel.sv
module aptr_step_sel
  import aptr_pkg::*;
(
  input  logic  step_one,
  input  logic  step_two,
  input  logic  blocked,
  output step_e step
);
  always_comb begin
    if (blocked)       step = STEP_NONE;
    else if (step_two) step = STEP_TWO;
    else if (step_one) step = STEP_ONE;
    else               step = STEP_NONE;
  end
endmodule

// File: rtl/aptr_next.sv
module aptr_next
  import aptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input  logic [PTR_W-1:0]  cur,
  input  step_e             step,
  input  logic              wr_hit,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  nxt
);
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] v, input step_e s);
    case (s)
      STEP_ONE: bump = v + PTR_W'(1);
      STEP_TWO: bump = v + PTR_W'(2);
      default:  bump = v;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] load_byte(input logic [PTR_W-1:0] v,
                                                 input logic hi,
                                                 input logic [BYTE_W-1:0] d);
    logic [PTR_W-1:0] r;
    r = v;
    if (hi) r[PTR_W-1:BYTE_W] = d;
    else    r[BYTE_W-1:0]     = d;
    return r;
  endfunction

  always_comb begin
    if (wr_hit) nxt = load_byte(cur, wr_sel, wdata);
    else        nxt = bump(cur, step);
  end
endmodule

// File: rtl/aptr_rd_mux.sv
module aptr_rd_mux #(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input  logic [PTR_W-1:0]  cur,
  input  logic              sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              byte_sel,
  input  logic              ovr_lo,
  input  logic              ovr_hi,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_oe
);
  logic cpu_rd;
  assign cpu_rd = sel & rd_en & ~wr_en;

  always_comb begin
    rdata    = '0;
    rdata_oe = 1'b0;
    if (ovr_lo) begin
      rdata    = cur[BYTE_W-1:0];
      rdata_oe = 1'b1;
    end else if (ovr_hi) begin
      rdata    = cur[PTR_W-1:BYTE_W];
      rdata_oe = 1'b1;
    end else if (cpu_rd) begin
      rdata    = byte_sel ? cur[PTR_W-1:BYTE_W] : cur[BYTE_W-1:0];
      rdata_oe = 1'b1;
    end
  end
endmodule

// File: rtl/auto_ptr_reg.sv
module auto_ptr_reg
  import aptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              byte_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              step_one,
  input  logic              step_two,
  input  logic              ovr_lo,
  input  logic              ovr_hi,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_oe,
  output logic [PTR_W-1:0]  ptr_q
);
  logic             wr_hit;
  step_e            step;
  logic [PTR_W-1:0] ptr_nxt;

  assign wr_hit = sel & wr_en;

  aptr_step_sel u_step (
    .step_one (step_one),
    .step_two (step_two),
    .blocked  (wr_hit),
    .step     (step)
  );

  aptr_next #(.BYTE_W(BYTE_W)) u_next (
    .cur    (ptr_q),
    .step   (step),
    .wr_hit (wr_hit),
    .wr_sel (byte_sel),
    .wdata  (wdata),
    .nxt    (ptr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  aptr_rd_mux #(.BYTE_W(BYTE_W)) u_rd (
    .cur      (ptr_q),
    .sel      (sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .byte_sel (byte_sel),
    .ovr_lo   (ovr_lo),
    .ovr_hi   (ovr_hi),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );
endmodule

// File: rtl/aptr_checker.sv
module aptr_checker #(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic              byte_sel,
  input logic [BYTE_W-1:0] wdata,
  input logic              step_one,
  input logic              step_two,
  input logic              ovr_lo,
  input logic              ovr_hi,
  input logic [BYTE_W-1:0] rdata,
  input logic              rdata_oe,
  input logic [PTR_W-1:0]  ptr_q
);
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_one && !step_two && !wr_hit) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

  p_double_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_two && !wr_hit) |=> (ptr_q == $past(ptr_q) + PTR_W'(2)));

  p_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !byte_sel) |=> (ptr_q[BYTE_W-1:0] == $past(wdata)));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !byte_sel && (step_one || step_two)) |=>
      (ptr_q[PTR_W-1:BYTE_W] == $past(ptr_q[PTR_W-1:BYTE_W])));

  p_write_wins_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && byte_sel && (step_one || step_two)) |=>
      (ptr_q[BYTE_W-1:0] == $past(ptr_q[BYTE_W-1:0])));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !step_one && !step_two) |=> $stable(ptr_q));

  p_override_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_lo |-> (rdata_oe && rdata == ptr_q[BYTE_W-1:0]));

  p_override_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_hi && !ovr_lo) |-> (rdata_oe && rdata == ptr_q[PTR_W-1:BYTE_W]));
endmodule

bind auto_ptr_reg aptr_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_hit   (wr_hit),
  .byte_sel (byte_sel),
  .wdata    (wdata),
  .step_one (step_one),
  .step_two (step_two),
  .ovr_lo   (ovr_lo),
  .ovr_hi   (ovr_hi),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .ptr_q    (ptr_q)
);

// File: tb/auto_ptr_reg_test.sv
module auto_ptr_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, byte_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        step_one = 1'b0, step_two = 1'b0, ovr_lo = 1'b0, ovr_hi = 1'b0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [15:0] ptr_q;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  int unsigned model = 0;

  always #2.5 clk = ~clk;

  auto_ptr_reg uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_sel(byte_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .step_one(step_one), .step_two(step_two),
    .ovr_lo(ovr_lo), .ovr_hi(ovr_hi), .rdata(rdata), .rdata_oe(rdata_oe),
    .ptr_q(ptr_q)
  );

  function automatic int unsigned model_next(int unsigned v, bit w, bit hi,
                                             int unsigned d, bit s1, bit s2);
    if (w) begin
      if (hi) return (d << 8) | (v % 256);
      return (v / 256) * 256 + d;
    end
    if (s2) return (v + 2) % 65536;
    if (s1) return (v + 1) % 65536;
    return v;
  endfunction

  function automatic int unsigned model_bus(int unsigned v, bit ol, bit oh,
                                            bit s, bit r, bit w, bit hi);
    if (ol) return 256 + (v % 256);
    if (oh) return 256 + (v / 256);
    if (s && r && !w) return 256 + (hi ? v / 256 : v % 256);
    return 0;
  endfunction

  task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
    end
  endtask

  task automatic cycle(bit s, bit hi, bit w, bit r, int unsigned d,
                       bit s1, bit s2, bit ol, bit oh, string req);
    int unsigned bus;
    int unsigned nxt;
    sel = s; byte_sel = hi; wr_en = w; rd_en = r; wdata = 8'(d);
    step_one = s1; step_two = s2; ovr_lo = ol; ovr_hi = oh;
    #1;
    bus = model_bus(model, ol, oh, s, r, w, hi);
    check({23'd0, rdata_oe, rdata} == bus,
          (ol || oh) ? "R5 bus" : "R7 bus", {23'd0, rdata_oe, rdata}, bus);
    nxt = model_next(model, s && w, hi, d, s1, s2);
    @(posedge clk);
    @(negedge clk);
    model = nxt;
    check(ptr_q == 16'(model), req, ptr_q, model);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 hold");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000 && !done) begin
        done = 1;
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(ptr_q == 16'h0000, "R1 in reset", ptr_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ptr_q == 16'h0000, "R1 after reset", ptr_q, 0);
    idle();
    // R2 loads
    cycle(1, 0, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 low load");
    cycle(1, 1, 1, 0, 8'h12, 0, 0, 0, 0, "R2 high load");
    cycle(1, 0, 0, 1, 0, 0, 0, 0, 0, "R7 read low");
    cycle(1, 1, 0, 1, 0, 0, 0, 0, 0, "R7 read high");
    cycle(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3 carry into high byte");
    // R3 wrap
    cycle(1, 0, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 low load");
    cycle(1, 1, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 high load");
    cycle(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3 FFFF wraps to 0000");
    // R4 wraps
    cycle(1, 0, 1, 0, 8'hFE, 0, 0, 0, 0, "R2 low load");
    cycle(1, 1, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 high load");
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 FFFE wraps to 0000");
    cycle(1, 0, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 low load");
    cycle(1, 1, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 high load");
    cycle(0, 0, 0, 0, 0, 1, 1, 0, 0, "R4 both strobes FFFF to 0001");
    // R6 collisions near carry
    cycle(1, 0, 1, 0, 8'hFF, 0, 0, 0, 0, "R2 low load");
    cycle(1, 1, 1, 0, 8'h40, 1, 0, 0, 0, "R6 high write beats step");
    cycle(1, 0, 1, 0, 8'h7F, 0, 1, 0, 0, "R6 low write beats step");
    // R5 overrides versus normal decode
    cycle(0, 1, 0, 0, 0, 0, 0, 1, 0, "R5 low override, no select");
    cycle(1, 0, 0, 1, 0, 0, 0, 0, 1, "R5 high override beats read");
    cycle(1, 1, 1, 0, 8'h33, 0, 0, 1, 1, "R5 both overrides during write");
    cycle(1, 0, 1, 1, 8'h55, 0, 0, 0, 0, "R7 read with write gives no drive");
    idle();
    for (int i = 0; i < 400; i++) begin
      bit s, hi, w, r, s1, s2, ol, oh;
      s  = ($urandom % 2) == 0;
      hi = $urandom % 2;
      w  = ($urandom % 4) == 0;
      r  = $urandom % 2;
      s1 = ($urandom % 3) == 0;
      s2 = ($urandom % 4) == 0;
      ol = ($urandom % 8) == 0;
      oh = ($urandom % 8) == 0;
      cycle(s, hi, w, r, $urandom % 256, s1, s2, ol, oh,
            (s && w) ? ((s1 || s2) ? "R6 random" : "R2 random")
                     : (s2 ? "R4 random" : (s1 ? "R3 random" : "R8 random")));
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule